// File: doc/BRIEF.md
# Shift-Register Handshake Transfer Controller

This block is the host-side sequencer for half-duplex packet exchange with a peripheral microcontroller. The link is an 8-bit shift register plus three active-low handshake lines. The device drives the request line `req_n_i` low to ask for service or to continue a transfer. The host drives `tip_n_o` (transaction in progress) and `tack_n_o` (byte acknowledge). Serial bit clocking is outside the block. Each completed byte shift arrives as a one-cycle `shift_done_i` event together with the byte that was shifted in.

The controller moves through five states: listen, receive, receive-end, send-start and send.

- **Receiving.** Received bytes are collected into a 16-byte buffer. The controller acknowledges each byte by toggling the acknowledge line. When the packet completes, it reports the length and pulses `pkt_done_o`.
- **Sending.** A packet of up to 8 bytes can be queued while the controller is idle. A send begins only when the device is not requesting. The controller then feeds bytes to the shift register one event at a time.
- **Collision.** If the device asserts its request right after the first transmitted byte, this is treated as a collision. The send is aborted and the queued packet is kept for a later retry.

Top module: `shx_ctrl`

## Requirements
- R1: After reset the controller is idle (listen), with `tip_n_o`=1, `tack_n_o`=1, `dir_out_o`=0 (input), `busy_o`=0, `pkt_done_o`=0, `rx_len_o`=0, and no transmit packet pending.
- R2: In listen, a shift event with `req_n_i`=0 discards the shifted byte, drives `tip_n_o` low and enters receive. A shift event with `req_n_i`=1 while nothing is pending changes no output.
- R3: In receive, each shift event stores the byte at the next buffer index, with byte k at `rx_buf_o[8k+:8]`. If `req_n_i`=0 at that event, `tack_n_o` toggles. If `req_n_i`=1, both `tip_n_o` and `tack_n_o` go high and the controller enters receive-end.
- R4: The receive buffer holds 16 bytes. Further bytes are dropped while the handshake keeps toggling, and the reported length saturates at 16.
- R5: In receive-end, a shift event discards its byte and sets `rx_len_o` to the stored count. It pulses `pkt_done_o` high for exactly one cycle, starting the cycle after the event, and resets the index. If `req_n_i`=0, the controller drives `tip_n_o` low and re-enters receive. Otherwise it returns to listen.
- R6: A send starts only in listen, on a cycle with no shift event, with a nonzero pending count and `req_n_i`=1. On the following edge, `dir_out_o` becomes 1, `tx_byte_o` holds byte 0 and `tip_n_o` goes low.
- R7: In send-start, a shift event with `req_n_i`=0 is a collision. The controller sets `dir_out_o`=0, raises `tip_n_o` and `tack_n_o`, and returns to listen. The packet stays pending, and the retry sends from byte 0.
- R8: Without a collision, each shift event in send-start or send loads the next byte into `tx_byte_o` and toggles `tack_n_o`. The event after the last byte clears the pending packet, sets `dir_out_o`=0, raises `tip_n_o` and `tack_n_o`, and returns to listen.
- R9: `tx_load_i` is accepted only in listen. Byte i is taken from `tx_data_i[8i+:8]`. A `tx_len_i` above 8 is treated as 8, and a length of 0 leaves nothing pending.
- R10: `busy_o` is high exactly when the controller is not in listen.
- R11: A one-byte packet ends on the first shift event after the send starts, with no second byte loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| shift_done_i | input | 1 | One-cycle pulse: a byte shift completed |
| shift_rx_i | input | 8 | Byte shifted in from the device |
| req_n_i | input | 1 | Device request level, active low |
| tx_load_i | input | 1 | Queue a transmit packet (honoured in listen) |
| tx_len_i | input | 4 | Transmit byte count, clamped to 8 |
| tx_data_i | input | 64 | Transmit packet, byte i at bits 8i+7:8i |
| dir_out_o | output | 1 | Shift direction, 1 = output to device |
| tx_byte_o | output | 8 | Byte to load into the shift register |
| tip_n_o | output | 1 | Transaction in progress, active low |
| tack_n_o | output | 1 | Byte acknowledge, active low, toggled per byte |
| rx_buf_o | output | 128 | Receive buffer, byte k at bits 8k+7:8k |
| rx_len_o | output | 5 | Length of the last delivered packet |
| pkt_done_o | output | 1 | One-cycle pulse: a received packet was delivered |
| busy_o | output | 1 | High whenever the state is not listen |

## Verification
The assertions check the following on every cycle:
- the acknowledge line toggles on each continued receive byte;
- a collision always lands in listen with both host lines high and the direction set to input;
- the controller never enters send-start while the device is requesting;
- both host lines are high whenever the controller is idle;
- the delivery strobe is a single cycle;
- neither buffer index runs past its bound.

Only the bench scenarios can show the following:
- that received bytes land at the right buffer positions;
- that the length saturates at 16;
- that a collided packet is retried from its first byte;
- that one-byte and over-length packets end on the right event;
- that a load during a transfer is dropped.

// File: rtl/shx_pkg.sv
package shx_pkg;
  typedef enum logic [2:0] {
    ST_LISTEN,
    ST_RECV,
    ST_RECV_END,
    ST_SEND_START,
    ST_SEND
  } state_e;
endpackage

// File: rtl/shx_rx_store.sv
module shx_rx_store #(
  parameter int DEPTH = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_i,
  input  logic [7:0]               data_i,
  input  logic                     clr_i,
  output logic [DEPTH*8-1:0]       buf_o,
  output logic [$clog2(DEPTH+1)-1:0] len_o
);
  localparam int IW = $clog2(DEPTH + 1);
  localparam int AW = $clog2(DEPTH);

  logic [7:0]    mem_q [DEPTH];
  logic [IW-1:0] idx_q;
  logic          room;

  assign room = idx_q < IW'(DEPTH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      len_o <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (clr_i) begin
      len_o <= idx_q;
      idx_q <= '0;
    end else if (wr_i && room) begin
      mem_q[idx_q[AW-1:0]] <= data_i;
      idx_q <= idx_q + 1'b1;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_out
    assign buf_o[8*g +: 8] = mem_q[g];
  end

  a_r4_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= IW'(DEPTH));
endmodule

// File: rtl/shx_tx_store.sv
module shx_tx_store #(
  parameter int MAXB = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       load_i,
  input  logic [$clog2(MAXB+1)-1:0]  len_i,
  input  logic [MAXB*8-1:0]          data_i,
  input  logic                       first_i,
  input  logic                       next_i,
  input  logic                       end_i,
  input  logic                       abort_i,
  output logic [7:0]                 byte_o,
  output logic                       pend_o,
  output logic                       more_o
);
  localparam int LW = $clog2(MAXB + 1);
  localparam int AW = $clog2(MAXB);

  logic [7:0]    mem_q [MAXB];
  logic [LW-1:0] cnt_q;
  logic [LW-1:0] idx_q;

  assign pend_o = cnt_q != '0;
  assign more_o = idx_q < cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      idx_q  <= '0;
      byte_o <= '0;
      for (int i = 0; i < MAXB; i++) mem_q[i] <= '0;
    end else begin
      if (load_i) begin
        cnt_q <= (len_i > LW'(MAXB)) ? LW'(MAXB) : len_i;
        idx_q <= '0;
        for (int i = 0; i < MAXB; i++) mem_q[i] <= data_i[8*i +: 8];
      end else if (first_i) begin
        byte_o <= mem_q[0];
        idx_q  <= LW'(1);
      end else if (next_i) begin
        byte_o <= mem_q[idx_q[AW-1:0]];
        idx_q  <= idx_q + 1'b1;
      end else if (end_i) begin
        cnt_q <= '0;
        idx_q <= '0;
      end else if (abort_i) begin
        idx_q <= '0;
      end
    end
  end

  a_r8_idx_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= LW'(MAXB));
  a_r8_next_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    next_i |-> idx_q < cnt_q);
endmodule

// File: rtl/shx_fsm.sv
module shx_fsm
  import shx_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   ev_i,
  input  logic   req_n_i,
  input  logic   tx_load_i,
  input  logic   tx_pend_i,
  input  logic   tx_more_i,
  output state_e state_o,
  output logic   tip_n_o,
  output logic   tack_n_o,
  output logic   dir_out_o,
  output logic   done_o,
  output logic   rx_wr_o,
  output logic   rx_clr_o,
  output logic   tx_first_o,
  output logic   tx_next_o,
  output logic   tx_end_o,
  output logic   tx_abort_o
);
  state_e state_q, state_d;
  logic   tip_d, tack_d, dir_d, done_d;
  logic   start;

  // send may begin only on a quiet idle cycle
  assign start = (state_q == ST_LISTEN) && !ev_i && tx_pend_i && req_n_i && !tx_load_i;

  always_comb begin
    state_d    = state_q;
    tip_d      = tip_n_o;
    tack_d     = tack_n_o;
    dir_d      = dir_out_o;
    done_d     = 1'b0;
    rx_wr_o    = 1'b0;
    rx_clr_o   = 1'b0;
    tx_first_o = 1'b0;
    tx_next_o  = 1'b0;
    tx_end_o   = 1'b0;
    tx_abort_o = 1'b0;
    unique case (state_q)
      ST_LISTEN: begin
        if (ev_i && !req_n_i) begin
          tip_d   = 1'b0;
          state_d = ST_RECV;
        end else if (start) begin
          dir_d      = 1'b1;
          tx_first_o = 1'b1;
          tip_d      = 1'b0;
          state_d    = ST_SEND_START;
        end
      end
      ST_RECV: begin
        if (ev_i) begin
          rx_wr_o = 1'b1;
          if (!req_n_i) begin
            tack_d = ~tack_n_o;
          end else begin
            tack_d  = 1'b1;
            tip_d   = 1'b1;
            state_d = ST_RECV_END;
          end
        end
      end
      ST_RECV_END: begin
        if (ev_i) begin
          rx_clr_o = 1'b1;
          done_d   = 1'b1;
          if (!req_n_i) begin
            tip_d   = 1'b0;
            state_d = ST_RECV;
          end else begin
            state_d = ST_LISTEN;
          end
        end
      end
      ST_SEND_START: begin
        if (ev_i) begin
          if (!req_n_i) begin
            dir_d      = 1'b0;
            tip_d      = 1'b1;
            tack_d     = 1'b1;
            tx_abort_o = 1'b1;
            state_d    = ST_LISTEN;
          end else if (tx_more_i) begin
            tx_next_o = 1'b1;
            tack_d    = ~tack_n_o;
            state_d   = ST_SEND;
          end else begin
            tx_end_o = 1'b1;
            dir_d    = 1'b0;
            tip_d    = 1'b1;
            tack_d   = 1'b1;
            state_d  = ST_LISTEN;
          end
        end
      end
      ST_SEND: begin
        if (ev_i) begin
          if (tx_more_i) begin
            tx_next_o = 1'b1;
            tack_d    = ~tack_n_o;
          end else begin
            tx_end_o = 1'b1;
            dir_d    = 1'b0;
            tip_d    = 1'b1;
            tack_d   = 1'b1;
            state_d  = ST_LISTEN;
          end
        end
      end
      default: state_d = ST_LISTEN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_LISTEN;
      tip_n_o   <= 1'b1;
      tack_n_o  <= 1'b1;
      dir_out_o <= 1'b0;
      done_o    <= 1'b0;
    end else begin
      state_q   <= state_d;
      tip_n_o   <= tip_d;
      tack_n_o  <= tack_d;
      dir_out_o <= dir_d;
      done_o    <= done_d;
    end
  end

  assign state_o = state_q;

  a_r3_tack_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RECV && ev_i && !req_n_i) |=> (tack_n_o != $past(tack_n_o)));
  a_r7_collision: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SEND_START && ev_i && !req_n_i) |=>
      (state_q == ST_LISTEN && tip_n_o && tack_n_o && !dir_out_o));
  a_r6_no_start_on_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LISTEN && !req_n_i) |=> (state_q != ST_SEND_START));
  a_r2_idle_lines: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LISTEN) |-> (tip_n_o && tack_n_o && !dir_out_o));
  a_r5_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/shx_ctrl.sv
module shx_ctrl
  import shx_pkg::*;
#(
  parameter int RX_DEPTH = 16,
  parameter int TX_MAX   = 8,
  localparam int RLW = $clog2(RX_DEPTH + 1),
  localparam int TLW = $clog2(TX_MAX + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  shift_done_i,
  input  logic [7:0]            shift_rx_i,
  input  logic                  req_n_i,
  input  logic                  tx_load_i,
  input  logic [TLW-1:0]        tx_len_i,
  input  logic [TX_MAX*8-1:0]   tx_data_i,
  output logic                  dir_out_o,
  output logic [7:0]            tx_byte_o,
  output logic                  tip_n_o,
  output logic                  tack_n_o,
  output logic [RX_DEPTH*8-1:0] rx_buf_o,
  output logic [RLW-1:0]        rx_len_o,
  output logic                  pkt_done_o,
  output logic                  busy_o
);
  state_e state;
  logic   rx_wr, rx_clr, tx_first, tx_next, tx_end, tx_abort;
  logic   tx_pend, tx_more, load_ok;

  assign load_ok = tx_load_i && (state == ST_LISTEN);
  assign busy_o  = state != ST_LISTEN;

  shx_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ev_i       (shift_done_i),
    .req_n_i    (req_n_i),
    .tx_load_i  (load_ok),
    .tx_pend_i  (tx_pend),
    .tx_more_i  (tx_more),
    .state_o    (state),
    .tip_n_o    (tip_n_o),
    .tack_n_o   (tack_n_o),
    .dir_out_o  (dir_out_o),
    .done_o     (pkt_done_o),
    .rx_wr_o    (rx_wr),
    .rx_clr_o   (rx_clr),
    .tx_first_o (tx_first),
    .tx_next_o  (tx_next),
    .tx_end_o   (tx_end),
    .tx_abort_o (tx_abort)
  );

  shx_rx_store #(.DEPTH(RX_DEPTH)) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (rx_wr),
    .data_i (shift_rx_i),
    .clr_i  (rx_clr),
    .buf_o  (rx_buf_o),
    .len_o  (rx_len_o)
  );

  shx_tx_store #(.MAXB(TX_MAX)) u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_ok),
    .len_i   (tx_len_i),
    .data_i  (tx_data_i),
    .first_i (tx_first),
    .next_i  (tx_next),
    .end_i   (tx_end),
    .abort_i (tx_abort),
    .byte_o  (tx_byte_o),
    .pend_o  (tx_pend),
    .more_o  (tx_more)
  );

  a_r10_busy_on_send: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dir_out_o) |-> busy_o);
endmodule

// File: tb/shx_ctrl_test.sv
module shx_ctrl_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ev = 1'b0;
  logic [7:0]   rx = '0;
  logic         req_n = 1'b1;
  logic         load = 1'b0;
  logic [3:0]   len = '0;
  logic [63:0]  txd = '0;
  logic         dir, tip_n, tack_n, done, busy;
  logic [7:0]   txb;
  logic [127:0] rbuf;
  logic [4:0]   rlen;
  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  shx_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .shift_done_i(ev), .shift_rx_i(rx),
    .req_n_i(req_n), .tx_load_i(load), .tx_len_i(len), .tx_data_i(txd),
    .dir_out_o(dir), .tx_byte_o(txb), .tip_n_o(tip_n), .tack_n_o(tack_n),
    .rx_buf_o(rbuf), .rx_len_o(rlen), .pkt_done_o(done), .busy_o(busy)
  );

  typedef struct packed {
    logic       req_n;
    logic [7:0] data;
    logic       busy;
    logic       tip_n;
    logic       tack_n;
    logic       done;
    logic [4:0] len;
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 5'd0},
    '{1'b0, 8'hA1, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0},
    '{1'b0, 8'hA2, 1'b1, 1'b0, 1'b1, 1'b0, 5'd0},
    '{1'b1, 8'hA3, 1'b1, 1'b1, 1'b1, 1'b0, 5'd0},
    '{1'b1, 8'hFF, 1'b0, 1'b1, 1'b1, 1'b1, 5'd3},
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 5'd3},
    '{1'b1, 8'hB1, 1'b1, 1'b1, 1'b1, 1'b0, 5'd3},
    '{1'b0, 8'hEE, 1'b1, 1'b0, 1'b1, 1'b1, 5'd1},
    '{1'b1, 8'hC1, 1'b1, 1'b1, 1'b1, 1'b0, 5'd1},
    '{1'b1, 8'hDD, 1'b0, 1'b1, 1'b1, 1'b1, 5'd1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic shift(input logic rq, input logic [7:0] d);
    @(negedge clk);
    ev = 1'b1; req_n = rq; rx = d;
    @(negedge clk);
    ev = 1'b0;
  endtask

  // load spans one edge; the send (if allowed) starts on the next edge
  task automatic queue(input logic [3:0] n, input logic [63:0] d);
    @(negedge clk);
    load = 1'b1; len = n; txd = d;
    @(negedge clk);
    load = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 tip", tip_n, 1);
    chk("R1 tack", tack_n, 1);
    chk("R1 dir", dir, 0);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 len", rlen, 0);

    // R2 event with no request and nothing pending is ignored
    shift(1'b1, 8'h5A);
    chk("R2 ignore busy", busy, 0);
    chk("R2 ignore tip", tip_n, 1);
    chk("R2 ignore tack", tack_n, 1);

    // R2 R3 R5 R10 table-driven receive sequences
    for (int i = 0; i < 10; i++) begin
      shift(VEC[i].req_n, VEC[i].data);
      chk("R10 table busy", busy, VEC[i].busy);
      chk("R3 table tip", tip_n, VEC[i].tip_n);
      chk("R3 table tack", tack_n, VEC[i].tack_n);
      chk("R5 table done", done, VEC[i].done);
      chk("R5 table len", rlen, VEC[i].len);
      chk("R2 table dir", dir, 0);
      if (i == 4) begin
        chk("R3 byte0", rbuf[7:0], 8'hA1);
        chk("R3 byte1", rbuf[15:8], 8'hA2);
        chk("R3 byte2", rbuf[23:16], 8'hA3);
      end
    end
    chk("R5 back-to-back byte0", rbuf[7:0], 8'hC1);
    @(negedge clk);
    chk("R5 done one cycle", done, 0);

    // R4 overflow: 20 data bytes, 16 kept
    shift(1'b0, 8'h00);
    for (int i = 0; i < 19; i++) shift(1'b0, 8'(8'h30 + i));
    chk("R4 handshake continues", tack_n, 0);
    shift(1'b1, 8'h50);
    shift(1'b1, 8'h00);
    chk("R4 len saturates", rlen, 16);
    chk("R4 last kept", rbuf[127:120], 8'h3F);

    // R6 R8 three-byte send
    queue(4'd3, 64'h33_22_11);
    chk("R6 start busy", busy, 1);
    chk("R6 start dir", dir, 1);
    chk("R6 start byte0", txb, 8'h11);
    chk("R6 start tip", tip_n, 0);
    shift(1'b1, 8'h00);
    chk("R8 byte1", txb, 8'h22);
    chk("R8 tack toggle", tack_n, 0);
    shift(1'b1, 8'h00);
    chk("R8 byte2", txb, 8'h33);
    chk("R8 tack toggle2", tack_n, 1);
    shift(1'b1, 8'h00);
    chk("R8 end busy", busy, 0);
    chk("R8 end dir", dir, 0);
    chk("R8 end tip", tip_n, 1);
    repeat (3) @(negedge clk);
    chk("R8 pending cleared", busy, 0);

    // R6 R7 blocked start, collision, retry
    req_n = 1'b0;
    queue(4'd2, 64'h55_44);
    @(negedge clk);
    chk("R6 no start while requested", busy, 0);
    req_n = 1'b1;
    @(negedge clk);
    chk("R6 start after release", txb, 8'h44);
    chk("R6 start dir2", dir, 1);
    shift(1'b0, 8'h99);
    chk("R7 collision busy", busy, 0);
    chk("R7 collision dir", dir, 0);
    chk("R7 collision tip", tip_n, 1);
    chk("R7 collision tack", tack_n, 1);
    @(negedge clk);
    chk("R7 held off", busy, 0);
    req_n = 1'b1;
    @(negedge clk);
    chk("R7 retry busy", busy, 1);
    chk("R7 retry byte0", txb, 8'h44);
    shift(1'b1, 8'h00);
    chk("R7 retry byte1", txb, 8'h55);
    shift(1'b1, 8'h00);
    chk("R7 retry done", busy, 0);

    // R5 pending send starts after a received packet returns to listen
    req_n = 1'b0;
    queue(4'd2, 64'h66_65);
    shift(1'b0, 8'h00);
    shift(1'b1, 8'h71);
    shift(1'b1, 8'h00);
    chk("R5 back in listen", busy, 0);
    chk("R5 len1", rlen, 1);
    @(negedge clk);
    chk("R5 then send starts", dir, 1);
    chk("R5 then byte0", txb, 8'h65);
    shift(1'b1, 8'h00);
    shift(1'b1, 8'h00);
    chk("R8 second send done", busy, 0);

    // R11 one-byte packet
    queue(4'd1, 64'h77);
    chk("R11 start byte", txb, 8'h77);
    shift(1'b1, 8'h00);
    chk("R11 ends busy", busy, 0);
    chk("R11 ends byte", txb, 8'h77);
    chk("R11 ends dir", dir, 0);

    // R9 length clamp to 8
    queue(4'd15, 64'hA7_A6_A5_A4_A3_A2_A1_A0);
    chk("R9 clamp start", txb, 8'hA0);
    for (int i = 1; i < 8; i++) shift(1'b1, 8'h00);
    chk("R9 clamp last byte", txb, 8'hA7);
    chk("R9 clamp still busy", busy, 1);
    shift(1'b1, 8'h00);
    chk("R9 clamp end", busy, 0);

    // R9 zero length leaves nothing pending
    queue(4'd0, 64'h12);
    chk("R9 zero len", busy, 0);

    // R9 load while busy is dropped
    shift(1'b0, 8'h00);
    @(negedge clk);
    load = 1'b1; len = 4'd2; txd = 64'h88_87;
    @(negedge clk);
    load = 1'b0;
    shift(1'b1, 8'h01);
    shift(1'b1, 8'h00);
    repeat (3) @(negedge clk);
    chk("R9 busy load dropped", busy, 0);
    chk("R9 busy load dir", dir, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule